// File: doc/BRIEF.md
# Write-Completion Status Read Path

This block builds the byte that a non-volatile memory returns to its host on a read. While no self-timed program cycle is running, a read returns the byte stored in the array at the requested address. While the write controller reports a program cycle in progress, a read returns a status word instead of array contents. A host can poll that word to learn when the write has finished.

The status word has two signals. The top data bit carries the inverse of the top bit of the byte most recently written, at whatever address is read, so it reads back true only after programming ends. The bit just below it changes value once per read access, so two back-to-back accesses that agree mean the cycle is over. The block takes the three active-low strobes as synchronous signals. It presents the read address to a synchronous array with one cycle of latency and registers both the data word and the enable for the external tri-state drivers.

The undefined low status bits are driven as zero. Every result appears on the third rising clock edge after the strobes, the address, the busy flag and the written-byte top bit are sampled.

Top module: `wcs_read_path`

## Requirements
- R1: `dout_oe` is 1 exactly when the strobes sampled three edges earlier had `we_n`=1, `ce_n`=0 and `oe_n`=0, and is 0 for every other strobe combination.
- R2: Whenever `dout_oe` is 0, `dout` is all zeros.
- R3: When the busy flag sampled with a read is 0, `dout` equals the array word at `rd_addr`. The block registers `rd_addr` onto `arr_raddr` one edge after sampling it, and the array returns `arr_rdata` one edge after that.
- R4: When the busy flag sampled with a read is 1, `dout` bit DATA_W-1 (bit 7 by default) is the complement of `last_wr_msb`, independent of `rd_addr`.
- R5: When the busy flag sampled with a read is 1, `dout` bits DATA_W-3 down to 0 (bits 5:0 by default) are zero.
- R6: An access starts on a cycle where the read condition of R1 holds after a cycle where it did not. Each access start with busy=1 inverts the toggle state, and `dout` bit DATA_W-2 (bit 6 by default) shows the toggle state during busy reads. A read held over several cycles keeps one value.
- R7: While busy=0 the toggle state does not change. A read that is still held when busy falls switches to true array data. The next busy period continues from the frozen toggle state.
- R8: Synchronous active-high `rst` clears `dout`, `dout_oe` and the toggle state. As a result, the first busy read after reset shows bit DATA_W-2 as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| rd_addr | input | ADDR_W | Read address |
| busy | input | 1 | Program cycle in progress, from the write controller |
| last_wr_msb | input | 1 | Top bit of the byte most recently written |
| arr_raddr | output | ADDR_W | Registered read address to the synchronous array |
| arr_rdata | input | DATA_W | Array word, one cycle after `arr_raddr` |
| dout | output | DATA_W | Read data toward the bus drivers |
| dout_oe | output | 1 | Drive enable for the tri-state bus drivers |

## Verification
Each result is due on the third rising edge after its inputs are sampled. The strobes, busy flag and written-byte bit move through two pipeline registers before the output register. The address goes through `arr_raddr` and the array's own register. The bench changes inputs only on falling edges and compares outputs three falling edges later, exactly one half cycle after the edge that produced them. The toggle checks hold the inputs for one idle cycle between reads so that every access start is sampled, and they hold a read for extra cycles to show that a held access does not move bit 6.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    RM_IDLE   = 2'd0,
    RM_TRUE   = 2'd1,
    RM_STATUS = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/wcs_strobe_pipe.sv
// Two-stage pipeline of read condition, busy flag and written-byte top bit.
module wcs_strobe_pipe (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic busy,
  input  logic last_msb,
  output logic rd_s1,
  output logic busy_s1,
  output logic rd_s2,
  output logic busy_s2,
  output logic msb_s2,
  output logic acc_start
);
  logic msb_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_s1   <= 1'b0;
      busy_s1 <= 1'b0;
      msb_s1  <= 1'b0;
      rd_s2   <= 1'b0;
      busy_s2 <= 1'b0;
      msb_s2  <= 1'b0;
    end else begin
      rd_s1   <= ~ce_n & ~oe_n & we_n;
      busy_s1 <= busy;
      msb_s1  <= last_msb;
      rd_s2   <= rd_s1;
      busy_s2 <= busy_s1;
      msb_s2  <= msb_s1;
    end
  end

  // new access: read condition now, none the cycle before
  assign acc_start = rd_s1 & ~rd_s2;

  // R6: a start is never reported on two consecutive cycles
  assert_single_start_R6: assert property (@(posedge clk) disable iff (rst)
    acc_start |=> !acc_start);
endmodule

// File: rtl/wcs_fetch.sv
// Registered address toward the synchronous array.
module wcs_fetch #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] arr_raddr
);
  always_ff @(posedge clk) begin
    if (rst) arr_raddr <= '0;
    else     arr_raddr <= rd_addr;
  end

  // R3: the array sees the address sampled one edge earlier
  assert_addr_stage_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> arr_raddr == $past(rd_addr));
endmodule

// File: rtl/wcs_toggle.sv
// Toggle state: inverts once per access start during a program cycle.
module wcs_toggle (
  input  logic clk,
  input  logic rst,
  input  logic acc_start,
  input  logic busy_s1,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (rst) tog <= 1'b0;
    else if (acc_start && busy_s1) tog <= ~tog;
  end

  assert_tog_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_start && busy_s1) |=> tog != $past(tog));

  assert_tog_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_s1 |=> $stable(tog));
endmodule

// File: rtl/wcs_out_mux.sv
// Selects true data or status word and registers the bus outputs.
module wcs_out_mux
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_s2,
  input  logic              busy_s2,
  input  logic              msb_s2,
  input  logic              tog,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  rd_mode_e          mode;
  logic [DATA_W-1:0] status_w;

  always_comb begin
    if (!rd_s2)       mode = RM_IDLE;
    else if (busy_s2) mode = RM_STATUS;
    else              mode = RM_TRUE;
  end

  always_comb begin
    status_w           = '0;
    status_w[POLL_BIT] = ~msb_s2;
    status_w[TOG_BIT]  = tog;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      case (mode)
        RM_TRUE: begin
          dout    <= arr_rdata;
          dout_oe <= 1'b1;
        end
        RM_STATUS: begin
          dout    <= status_w;
          dout_oe <= 1'b1;
        end
        default: begin
          dout    <= '0;
          dout_oe <= 1'b0;
        end
      endcase
    end
  end

  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> (dout == '0 && !dout_oe));
endmodule

// File: rtl/wcs_read_path.sv
// Read data path with program-cycle status reporting.
module wcs_read_path #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              last_wr_msb,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  localparam int LOW_TOP = DATA_W - 3;

  logic rd_s1, busy_s1, rd_s2, busy_s2, msb_s2, acc_start, tog;

  wcs_strobe_pipe u_pipe (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .last_msb(last_wr_msb),
    .rd_s1(rd_s1), .busy_s1(busy_s1), .rd_s2(rd_s2), .busy_s2(busy_s2),
    .msb_s2(msb_s2), .acc_start(acc_start)
  );

  wcs_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .arr_raddr(arr_raddr)
  );

  wcs_toggle u_tog (
    .clk(clk), .rst(rst), .acc_start(acc_start), .busy_s1(busy_s1), .tog(tog)
  );

  wcs_out_mux #(.DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst(rst), .rd_s2(rd_s2), .busy_s2(busy_s2), .msb_s2(msb_s2),
    .tog(tog), .arr_rdata(arr_rdata), .dout(dout), .dout_oe(dout_oe)
  );

  // edges since reset release, saturating, so $past(...,3) is meaningful
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  wire warm = (age == 2'd3);

  assert_oe_match_R1: assert property (@(posedge clk) disable iff (rst)
    warm |-> dout_oe == $past(~ce_n & ~oe_n & we_n, 3));

  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> dout == '0);

  assert_true_data_R3: assert property (@(posedge clk) disable iff (rst)
    (warm && dout_oe && !$past(busy, 3)) |-> dout == $past(arr_rdata));

  assert_poll_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (warm && dout_oe && $past(busy, 3)) |-> dout[DATA_W-1] == ~$past(last_wr_msb, 3));

  assert_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (warm && dout_oe && $past(busy, 3)) |-> dout[LOW_TOP:0] == '0);
endmodule

// File: tb/tb_wcs_read_path.sv
module tb_wcs_read_path;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              busy = 1'b0, last_wr_msb = 1'b0;
  logic [ADDR_W-1:0] arr_raddr;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] dout;
  logic              dout_oe;

  int total = 0;
  int bad = 0;
  logic exp_tog = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rom(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1};
  endfunction

  // synchronous array model: one cycle read latency
  always_ff @(posedge clk) arr_rdata <= rom(arr_raddr);

  wcs_read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_addr(rd_addr), .busy(busy), .last_wr_msb(last_wr_msb),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input logic eoe, input logic [7:0] ed);
    total++;
    if (dout_oe !== eoe || dout !== ed) begin
      bad++;
      $display("FAIL %s: oe=%b dout=%h expected oe=%b dout=%h", req, dout_oe, dout, eoe, ed);
    end
  endtask

  task automatic drive(input logic c, input logic o, input logic w, input logic [14:0] a);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; rd_addr = a;
  endtask

  task automatic wait3;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] stat();
    return {~last_wr_msb, exp_tog, 6'b0};
  endfunction

  // one read access followed by one idle cycle
  task automatic do_read(input logic [14:0] a, input string req);
    logic [7:0] e;
    drive(1'b0, 1'b0, 1'b1, a);
    if (busy) exp_tog = ~exp_tog;
    wait3;
    e = busy ? stat() : rom(a);
    chk(req, 1'b1, e);
    drive(1'b1, 1'b1, 1'b1, a);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk("R8 reset outputs", 1'b0, 8'h00);
    rst = 1'b0;
    wait3;
    chk("R8 idle after reset", 1'b0, 8'h00);
  endtask

  task automatic t_idle_reads;
    do_read(15'h0000, "R3 read addr 0000");
    do_read(15'h7FFF, "R3 read addr 7FFF");
    do_read(15'h1234, "R3 read addr 1234");
    do_read(15'h4A5C, "R3 read addr 4A5C");
  endtask

  task automatic t_inhibit;
    busy = 1'b1; last_wr_msb = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 15'h0011); wait3;
    chk("R1/R2 chip deselected", 1'b0, 8'h00);
    drive(1'b0, 1'b1, 1'b1, 15'h0022); wait3;
    chk("R1/R2 output strobe high", 1'b0, 8'h00);
    drive(1'b0, 1'b0, 1'b0, 15'h0033); wait3;
    chk("R1/R2 write strobe low", 1'b0, 8'h00);
    drive(1'b1, 1'b1, 1'b1, 15'h0000);
    // no access started above: the first busy read is the first flip (R8 clear state)
    do_read(15'h0044, "R8/R6 first busy read after reset");
  endtask

  task automatic t_poll;
    busy = 1'b1;
    last_wr_msb = 1'b1;
    do_read(15'h0100, "R4/R5 msb=1 addr 0100");
    last_wr_msb = 1'b0;
    do_read(15'h6ABC, "R4/R5 msb=0 addr 6ABC");
    do_read(15'h0001, "R4/R6 msb=0 addr 0001");
  endtask

  task automatic t_toggle_hold;
    busy = 1'b1; last_wr_msb = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 15'h0200);
    exp_tog = ~exp_tog;
    wait3;
    chk("R6 held access first sample", 1'b1, stat());
    repeat (2) @(negedge clk);
    chk("R6 held access unchanged", 1'b1, stat());
    drive(1'b1, 1'b1, 1'b1, 15'h0200);
    do_read(15'h0200, "R6 next access flips");
  endtask

  task automatic t_complete;
    logic frozen;
    busy = 1'b1; last_wr_msb = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 15'h0321);
    exp_tog = ~exp_tog;
    wait3;
    chk("R4 status before completion", 1'b1, stat());
    @(negedge clk); busy = 1'b0;
    wait3;
    chk("R7 held read turns to true data", 1'b1, rom(15'h0321));
    drive(1'b1, 1'b1, 1'b1, 15'h0321);
    frozen = exp_tog;
    do_read(15'h0321, "R7 true data after completion");
    do_read(15'h0777, "R7 true data other address");
    busy = 1'b1;
    do_read(15'h0777, "R7 toggle resumes from frozen");
    if (exp_tog == frozen) begin
      total++; bad++;
      $display("FAIL R7: model toggle %b expected %b", exp_tog, ~frozen);
    end
    busy = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_reads();
    t_inhibit();
    t_poll();
    t_toggle_hold();
    t_complete();
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule